// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block owns the fetch address of a five-stage in-order pipeline and settles conditional branches while the branch is still in decode. Decode supplies the branch kind, the two source register indices, the two operand values it has read, and the 16-bit offset. The block compares the operands for equality or inequality. A dedicated adder adds the scaled, sign-extended offset to the incremented address of the decoding instruction. The block then chooses the next fetch address in the same cycle.

Because the decision is made one stage after fetch, only one younger instruction is already in flight when a branch is taken. That instruction is the architectural delay slot. It is never cancelled, so no cycle is lost to a flush. The block also keeps the incremented address of the instruction in decode, which is the base for the target adder.

The comparison needs its operands in decode. A branch that reads a register being written by the instruction directly ahead of it, which is now in execute, therefore holds decode for one cycle. Instruction memory, the register file and the decoder sit outside the block.

Top module: `nxp_resolver`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` and `dec_pc4` both hold the parameter `RESET_PC`, `br_taken` is low, and no stall is raised for a non-branch.
- R2: When `dec_kind` is 0 or 3 (not a branch), `fetch_pc` advances by 4 on each clock, `dec_pc4` takes the old `fetch_pc` plus 4, and `br_taken` stays low.
- R3: With `dec_kind` = 1 (branch if equal) and `dec_opa` equal to `dec_opb`, `br_taken` is high and the next `fetch_pc` is `br_target`.
- R4: With `dec_kind` = 2 (branch if not equal) and the operands different, `br_taken` is high and the next `fetch_pc` is `br_target`.
- R5: A branch whose condition fails leaves `br_taken` low, and `fetch_pc` advances by 4.
- R6: `br_target` equals `dec_pc4` plus the 16-bit `dec_imm`, sign-extended and shifted left by 2. This covers backward offsets and the most negative offset.
- R7: In the clock after a taken branch, the instruction that follows the branch enters decode (`dec_pc4` equals the branch's `dec_pc4` plus 4) and is not cancelled. The target is fetched in that same cycle, so the penalty is one slot.
- R8: A branch (kind 1 or 2) whose `dec_rs` or `dec_rt` equals a nonzero `ex_wr_idx` while `ex_wr_en` is high raises `dec_stall`, keeps `br_taken` low, and holds `fetch_pc` and `dec_pc4` for that clock.
- R9: No stall is raised when `ex_wr_idx` is 0, when `ex_wr_en` is low, or when the decoding instruction is not a branch, even if the indices match.
- R10: After a one-cycle stall, the same branch resolves with the operands presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dec_kind | input | 2 | Branch kind in decode: 0 none, 1 equal, 2 not equal, 3 none |
| dec_rs | input | RIDX_W | First source register index of the decoding instruction |
| dec_rt | input | RIDX_W | Second source register index of the decoding instruction |
| dec_opa | input | XLEN | Value read for the first source |
| dec_opb | input | XLEN | Value read for the second source |
| dec_imm | input | IMM_W | Branch offset in instruction words |
| ex_wr_en | input | 1 | The instruction in execute writes a register |
| ex_wr_idx | input | RIDX_W | Destination index of the instruction in execute |
| fetch_pc | output | XLEN | Address fetched this cycle |
| dec_pc4 | output | XLEN | Incremented address of the instruction in decode |
| dec_stall | output | 1 | Hold fetch and decode, insert a bubble into execute |
| br_taken | output | 1 | Branch in decode is taken this cycle |
| br_target | output | XLEN | Computed branch target |

## Verification
Both branch kinds are driven with equal and with unequal operands. This shows that the comparator polarity follows the kind, and that a failing condition falls through by exactly 4. The offsets used are positive, negative, and the most negative 16-bit value, which exposes a missing sign extension or a wrong scale in the target adder. Hazard patterns match on either source index, match on register 0, match with the write enable low, and match on a non-branch. Together they separate a true interlock from a spurious one. Each taken branch is followed by the cycle in which its delay slot arrives in decode, which confirms that the slot survives and that the penalty is one cycle.

// File: rtl/nxp_pkg.sv
package nxp_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQ   = 2'd1,
    BK_NE   = 2'd2,
    BK_RSV  = 2'd3
  } br_kind_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned INSN_SHIFT = $clog2(INSN_BYTES);
endpackage

// File: rtl/nxp_cond.sv
module nxp_cond #(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            is_branch,
  output logic            cond_true
);
  import nxp_pkg::*;

  logic same;

  assign same = (opa == opb);

  always_comb begin
    is_branch = 1'b0;
    cond_true = 1'b0;
    unique case (br_kind_e'(kind))
      BK_EQ: begin
        is_branch = 1'b1;
        cond_true = same;
      end
      BK_NE: begin
        is_branch = 1'b1;
        cond_true = !same;
      end
      default: begin
        is_branch = 1'b0;
        cond_true = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nxp_target.sv
module nxp_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  base_pc4,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  target
);
  import nxp_pkg::*;

  localparam int unsigned EXT_W = XLEN - IMM_W - INSN_SHIFT;

  logic [XLEN-1:0] offset;

  assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, {INSN_SHIFT{1'b0}}};
  assign target = base_pc4 + offset;
endmodule

// File: rtl/nxp_hazard.sv
module nxp_hazard #(
  parameter int unsigned RIDX_W = 5
) (
  input  logic              is_branch,
  input  logic [RIDX_W-1:0] src_a,
  input  logic [RIDX_W-1:0] src_b,
  input  logic              prod_we,
  input  logic [RIDX_W-1:0] prod_idx,
  output logic              hold
);
  localparam int unsigned NSRC = 2;

  logic [RIDX_W-1:0] srcs [NSRC];
  logic [NSRC-1:0]   hit;
  logic              prod_live;

  assign srcs[0]   = src_a;
  assign srcs[1]   = src_b;
  assign prod_live = prod_we && (prod_idx != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = prod_live && (srcs[g] == prod_idx);
  end

  assign hold = is_branch && (|hit);
endmodule

// File: rtl/nxp_resolver.sv
module nxp_resolver #(
  parameter int unsigned    XLEN     = 32,
  parameter int unsigned    IMM_W    = 16,
  parameter int unsigned    RIDX_W   = 5,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        dec_kind,
  input  logic [RIDX_W-1:0] dec_rs,
  input  logic [RIDX_W-1:0] dec_rt,
  input  logic [XLEN-1:0]   dec_opa,
  input  logic [XLEN-1:0]   dec_opb,
  input  logic [IMM_W-1:0]  dec_imm,
  input  logic              ex_wr_en,
  input  logic [RIDX_W-1:0] ex_wr_idx,
  output logic [XLEN-1:0]   fetch_pc,
  output logic [XLEN-1:0]   dec_pc4,
  output logic              dec_stall,
  output logic              br_taken,
  output logic [XLEN-1:0]   br_target
);
  import nxp_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic            is_br;
  logic            cond_ok;
  logic            hold;
  logic            adv_en;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] fpc_q, fpc_d;
  logic [XLEN-1:0] dpc4_q, dpc4_d;

  nxp_cond #(.XLEN(XLEN)) u_cond (
    .kind      (dec_kind),
    .opa       (dec_opa),
    .opb       (dec_opb),
    .is_branch (is_br),
    .cond_true (cond_ok)
  );

  nxp_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
    .base_pc4 (dpc4_q),
    .imm      (dec_imm),
    .target   (tgt)
  );

  nxp_hazard #(.RIDX_W(RIDX_W)) u_hzd (
    .is_branch (is_br),
    .src_a     (dec_rs),
    .src_b     (dec_rt),
    .prod_we   (ex_wr_en),
    .prod_idx  (ex_wr_idx),
    .hold      (hold)
  );

  // next-state: the slot instruction always moves into decode when not held
  always_comb begin
    adv_en = !hold;
    seq_pc = fpc_q + STEP;
    fpc_d  = (cond_ok && !hold) ? tgt : seq_pc;
    dpc4_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpc_q  <= RESET_PC;
      dpc4_q <= RESET_PC;
    end else if (adv_en) begin
      fpc_q  <= fpc_d;
      dpc4_q <= dpc4_d;
    end
  end

  assign fetch_pc  = fpc_q;
  assign dec_pc4   = dpc4_q;
  assign dec_stall = hold;
  assign br_taken  = cond_ok && !hold;
  assign br_target = tgt;
endmodule

// File: rtl/nxp_resolver_chk.sv
module nxp_resolver_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        dec_kind,
  input logic              ex_wr_en,
  input logic [RIDX_W-1:0] ex_wr_idx,
  input logic [XLEN-1:0]   fetch_pc,
  input logic [XLEN-1:0]   dec_pc4,
  input logic              dec_stall,
  input logic              br_taken,
  input logic [XLEN-1:0]   br_target
);
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |=> ($stable(fetch_pc) && $stable(dec_pc4)));

  a_r8_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_stall && br_taken));

  a_r9_stall_needs_writer: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (ex_wr_en && (ex_wr_idx != '0) && (dec_kind == 2'd1 || dec_kind == 2'd2)));

  a_r3_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (fetch_pc == $past(br_target)));

  a_r7_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (dec_pc4 == $past(dec_pc4) + XLEN'(4)));

  a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_stall && !br_taken) |=> (fetch_pc == $past(fetch_pc) + XLEN'(4)));

  a_r2_nonbranch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_kind == 2'd0 || dec_kind == 2'd3) |-> (!br_taken && !dec_stall));
endmodule

bind nxp_resolver nxp_resolver_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_kind  (dec_kind),
  .ex_wr_en  (ex_wr_en),
  .ex_wr_idx (ex_wr_idx),
  .fetch_pc  (fetch_pc),
  .dec_pc4   (dec_pc4),
  .dec_stall (dec_stall),
  .br_taken  (br_taken),
  .br_target (br_target)
);

// File: tb/sim_nxp_resolver.sv
module sim_nxp_resolver;
  localparam logic [31:0] RPC = 32'h0000_0100;

  logic        clk;
  logic        rst_n;
  logic [1:0]  dec_kind;
  logic [4:0]  dec_rs, dec_rt, ex_wr_idx;
  logic [31:0] dec_opa, dec_opb;
  logic [15:0] dec_imm;
  logic        ex_wr_en;
  logic [31:0] fetch_pc, dec_pc4, br_target;
  logic        dec_stall, br_taken;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] fpc;
    logic [31:0] dpc4;
    logic [31:0] tgt;
    logic        stl;
    logic        tk;
    logic        chk_tgt;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [31:0] m_fpc, m_dpc4;

  nxp_resolver #(.RESET_PC(RPC)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_kind(dec_kind), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_opa(dec_opa), .dec_opb(dec_opb), .dec_imm(dec_imm), .ex_wr_en(ex_wr_en),
    .ex_wr_idx(ex_wr_idx), .fetch_pc(fetch_pc), .dec_pc4(dec_pc4),
    .dec_stall(dec_stall), .br_taken(br_taken), .br_target(br_target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: sets one decode cycle, pushes the expectation, advances one clock
  task automatic drive(string tag, logic [1:0] k, logic [4:0] rs, logic [4:0] rt,
                       logic [31:0] a, logic [31:0] b, logic [15:0] imm,
                       logic we, logic [4:0] widx);
    exp_t e;
    logic cnd, stl, br;
    br  = (k == 2'd1) || (k == 2'd2);
    cnd = (k == 2'd1 && a == b) || (k == 2'd2 && a != b);
    stl = br && we && (widx != 5'd0) && (widx == rs || widx == rt);
    dec_kind = k; dec_rs = rs; dec_rt = rt; dec_opa = a; dec_opb = b;
    dec_imm = imm; ex_wr_en = we; ex_wr_idx = widx;
    e.fpc = m_fpc; e.dpc4 = m_dpc4; e.stl = stl; e.tk = cnd && !stl;
    e.tgt = m_dpc4 + {{14{imm[15]}}, imm, 2'b00};
    e.chk_tgt = br; e.tag = tag;
    sb.push_back(e);
    if (!stl) begin
      m_dpc4 = m_fpc + 32'd4;
      m_fpc  = e.tk ? e.tgt : m_fpc + 32'd4;
    end
    @(posedge clk); #2;
  endtask

  // monitor: compares at the falling edge, when all values are settled
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "fetch_pc", fetch_pc, e.fpc);
        check(e.tag, "dec_pc4", dec_pc4, e.dpc4);
        check(e.tag, "dec_stall", {31'd0, dec_stall}, {31'd0, e.stl});
        check(e.tag, "br_taken", {31'd0, br_taken}, {31'd0, e.tk});
        if (e.chk_tgt) check(e.tag, "br_target", br_target, e.tgt);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dec_kind = 2'd0; dec_rs = '0; dec_rt = '0; dec_opa = '0; dec_opb = '0;
    dec_imm = '0; ex_wr_en = 1'b0; ex_wr_idx = '0;
    m_fpc = RPC; m_dpc4 = RPC;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "fetch_pc", fetch_pc, RPC);
    check("R1", "dec_pc4", dec_pc4, RPC);
    check("R1", "br_taken", {31'd0, br_taken}, 32'd0);
    check("R1", "dec_stall", {31'd0, dec_stall}, 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    drive("R2", 2'd0, 5'd1, 5'd2, 32'd5, 32'd5, 16'd3, 1'b0, 5'd0);
    drive("R2", 2'd0, 5'd1, 5'd2, 32'd5, 32'd6, 16'd3, 1'b0, 5'd0);
    drive("R2", 2'd0, 5'd3, 5'd4, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
    // R3 + R6 taken equal, forward offset
    drive("R3", 2'd1, 5'd3, 5'd4, 32'hA5A5, 32'hA5A5, 16'd5, 1'b0, 5'd0);
    // R7 delay slot now in decode
    drive("R7", 2'd0, 5'd0, 5'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
    drive("R2", 2'd0, 5'd0, 5'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
    // R5 equal-branch not taken
    drive("R5", 2'd1, 5'd3, 5'd4, 32'd1, 32'd2, 16'd9, 1'b0, 5'd0);
    // R4 + R6 taken not-equal, backward offset
    drive("R4", 2'd2, 5'd6, 5'd7, 32'd1, 32'd2, 16'hFFFD, 1'b0, 5'd0);
    drive("R7", 2'd0, 5'd0, 5'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
    // R5 not-equal branch with equal operands
    drive("R5", 2'd2, 5'd6, 5'd7, 32'h77, 32'h77, 16'd4, 1'b0, 5'd0);
    // R8 hazard on first source, then R10 release with fresh values
    drive("R8", 2'd1, 5'd7, 5'd8, 32'd1, 32'd9, 16'd2, 1'b1, 5'd7);
    drive("R10", 2'd1, 5'd7, 5'd8, 32'd9, 32'd9, 16'd2, 1'b0, 5'd7);
    drive("R7", 2'd0, 5'd0, 5'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
    // R8 hazard on second source for not-equal
    drive("R8", 2'd2, 5'd2, 5'd11, 32'd1, 32'd3, 16'd6, 1'b1, 5'd11);
    drive("R10", 2'd2, 5'd2, 5'd11, 32'd4, 32'd4, 16'd6, 1'b1, 5'd12);
    // R9 spurious interlock cases
    drive("R9", 2'd1, 5'd0, 5'd5, 32'd0, 32'd0, 16'd1, 1'b1, 5'd0);
    drive("R7", 2'd0, 5'd0, 5'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
    drive("R9", 2'd1, 5'd5, 5'd6, 32'd3, 32'd4, 16'd1, 1'b0, 5'd5);
    drive("R9", 2'd0, 5'd5, 5'd6, 32'd3, 32'd3, 16'd1, 1'b1, 5'd5);
    // R2 reserved kind behaves as non-branch
    drive("R2", 2'd3, 5'd5, 5'd6, 32'd3, 32'd3, 16'd8, 1'b1, 5'd5);
    // R6 most negative offset
    drive("R6", 2'd1, 5'd1, 5'd2, 32'd0, 32'd0, 16'h8000, 1'b0, 5'd0);
    drive("R7", 2'd0, 5'd0, 5'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);
    drive("R2", 2'd0, 5'd0, 5'd0, 32'd0, 32'd0, 16'd0, 1'b0, 5'd0);

    @(negedge clk); #1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule